// File: doc/BRIEF.md
# Ping-Pong Bulk IN Packet Assembler

This block sits between user logic that produces a byte stream and the endpoint logic of a USB device that sends bulk IN packets. User bytes arrive on an 8-bit stream with data, last, valid and ready. The block gathers them into packets of at most 64 bytes in one of two alternating buffers, so that one buffer can fill while the endpoint reads the other. The whole block uses a single clock, nominally 48 MHz, and has no internal clock crossing.

Four events close a packet: the 64th byte is accepted, a byte carrying `last` is accepted, `flush_now` is high while bytes are pending, or `flush_tmo_en` is high and no byte has arrived for `TMO_CYCLES` cycles. If no flush condition holds, bytes stay in the buffer until a full packet has built up. A packet closed by `last` at exactly 64 bytes is followed by a zero-length packet, which tells the host that the transfer has ended. The endpoint sees the oldest closed packet as `ep_pkt_valid` and `ep_pkt_len`. It reads the bytes by address, with one cycle of read latency, and frees the buffer with `ep_ack`. Until that acknowledge arrives, a packet that has to be retried can be read again unchanged.

The fill side is a state machine with five states. `F_EMPTY` means the fill buffer is free and holds no bytes. `F_FILL` means the fill buffer holds some bytes. `F_WAIT` means a packet has just closed and the machine is waiting for the next buffer to become free. `F_ZLP_WAIT` is the same wait, but a zero-length packet is owed. `F_ZLP` closes the zero-length packet.

The transitions are as follows. From `F_EMPTY` or `F_FILL`, a close goes to `F_WAIT`, or to `F_ZLP_WAIT` when `last` fell on the 64th byte. With no close, pending bytes lead to `F_FILL` and no bytes lead to `F_EMPTY`. `F_WAIT` goes to `F_EMPTY`, and `F_ZLP_WAIT` goes to `F_ZLP`, once the selected buffer is no longer holding a packet. `F_ZLP` always goes to `F_WAIT`.

Top module: `usb_in_pktbuf`

## Requirements
- R1: After reset, `s_ready` is 1 and `ep_pkt_valid` is 0. A byte is taken only in a cycle where `s_valid` and `s_ready` are both 1.
- R2: Accepting a byte with `s_last`=1 closes the packet at once. Its `ep_pkt_len` equals the number of bytes accepted into it.
- R3: Accepting the 64th byte without `s_last` closes a 64-byte packet, and no zero-length packet follows it.
- R4: When `s_last` is on the 64th byte, the 64-byte packet is followed by a packet with `ep_pkt_len`=0.
- R5: `flush_now`=1 closes a packet holding one or more bytes. With no bytes pending, it produces no packet.
- R6: With `flush_tmo_en`=1, a partial packet closes about `TMO_CYCLES` cycles (at most `TMO_CYCLES`+1) after its last accepted byte. With `flush_tmo_en`=0, a partial packet is never closed by time.
- R7: One closed packet still leaves `s_ready` high. While both buffers hold closed packets, `s_ready` is 0.
- R8: Packets are offered in the order they were closed. Each one stays offered, unchanged and readable any number of times, until `ep_ack`=1 frees it.
- R9: `ep_ack` while `ep_pkt_valid`=0 has no effect.
- R10: `ep_rd_data` returns, one cycle after `ep_rd_addr` is set, the byte at that offset in the offered packet. Offset i holds the i-th byte accepted into that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 48 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8 | User byte |
| s_last | input | 1 | Close the packet after this byte |
| s_valid | input | 1 | User byte present |
| s_ready | output | 1 | Block can take a byte |
| flush_now | input | 1 | Close pending bytes immediately |
| flush_tmo_en | input | 1 | Allow close after idle timeout |
| ep_pkt_valid | output | 1 | A closed packet is offered |
| ep_pkt_len | output | 7 | Length of the offered packet, 0 to 64 |
| ep_rd_addr | input | 6 | Byte offset to read in the offered packet |
| ep_rd_data | output | 8 | Byte at the offset given one cycle earlier |
| ep_ack | input | 1 | Endpoint is done with the offered packet |

## Verification
The bench targets the 64-byte boundary in both forms. A design that confuses the two would either leave the transfer open after `last` on the 64th byte, or add a zero-length packet after a plain full packet. It checks that a flush on an empty buffer does nothing, since a careless design would send zero-length packets. It also checks that the idle timeout fires only while it is enabled, since a wrong design would close packets after an unenabled timeout or never close them. Finally, it fills both buffers without acknowledging either, which checks that `s_ready` drops, that the packets come out in order, and that a packet reread before its acknowledge returns the same bytes. A design that overwrote or reordered buffers would fail these checks.

// File: rtl/inbuf_pkg.sv
package inbuf_pkg;
    typedef enum logic [2:0] {
        F_EMPTY,
        F_FILL,
        F_WAIT,
        F_ZLP_WAIT,
        F_ZLP
    } fill_state_t;
endpackage

// File: rtl/inbuf_idle_timer.sv
module inbuf_idle_timer #(
    parameter int LIMIT = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clear)                 cnt <= '0;
        else if (cnt != CW'(LIMIT))     cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/inbuf_store.sv
module inbuf_store #(
    parameter int MAX_PKT = 64
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic                       wr_bank,
    input  logic [$clog2(MAX_PKT)-1:0] wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       rd_bank,
    input  logic [$clog2(MAX_PKT)-1:0] rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int AW = $clog2(MAX_PKT);
    logic [7:0] mem [2*MAX_PKT];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_bank, wr_addr}] <= wr_data;
        rd_data <= mem[{rd_bank, rd_addr}];
    end
endmodule

// File: rtl/inbuf_fill_fsm.sv
module inbuf_fill_fsm
    import inbuf_pkg::*;
#(
    parameter int MAX_PKT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_valid,
    input  logic                         s_last,
    input  logic                         flush_now,
    input  logic                         flush_tmo_en,
    input  logic                         tmo_hit,
    input  logic [1:0]                   bank_full,
    output logic                         s_ready,
    output logic                         accept,
    output logic                         wr_sel,
    output logic [$clog2(MAX_PKT)-1:0]   wr_addr,
    output logic                         fill_empty,
    output logic                         close,
    output logic [$clog2(MAX_PKT+1)-1:0] close_len
);
    localparam int AW = $clog2(MAX_PKT);
    localparam int LW = $clog2(MAX_PKT + 1);

    fill_state_t state, nxt;
    logic [LW-1:0] cnt, n_cnt;
    logic          want_close, zlp_owed;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= F_EMPTY;
            cnt    <= '0;
            wr_sel <= 1'b0;
        end else begin
            state <= nxt;
            if (close) begin
                cnt    <= '0;
                wr_sel <= ~wr_sel;
            end else begin
                cnt <= n_cnt;
            end
        end
    end

    // outputs and next state
    always_comb begin
        s_ready    = (state == F_EMPTY) || (state == F_FILL);
        accept     = s_ready && s_valid;
        n_cnt      = cnt + LW'(accept);
        want_close = (n_cnt != '0) &&
                     ((accept && s_last) || (n_cnt == LW'(MAX_PKT)) ||
                      flush_now || (flush_tmo_en && tmo_hit));
        zlp_owed   = accept && s_last && (n_cnt == LW'(MAX_PKT));
        close      = 1'b0;
        close_len  = n_cnt;
        nxt        = state;
        unique case (state)
            F_EMPTY, F_FILL: begin
                if (want_close) begin
                    close = 1'b1;
                    nxt   = zlp_owed ? F_ZLP_WAIT : F_WAIT;
                end else begin
                    nxt = (n_cnt != '0) ? F_FILL : F_EMPTY;
                end
            end
            F_WAIT:     if (!bank_full[wr_sel]) nxt = F_EMPTY;
            F_ZLP_WAIT: if (!bank_full[wr_sel]) nxt = F_ZLP;
            F_ZLP: begin
                close     = 1'b1;
                close_len = '0;
                nxt       = F_WAIT;
            end
            default: nxt = F_EMPTY;
        endcase
    end

    assign wr_addr    = cnt[AW-1:0];
    assign fill_empty = (cnt == '0);

    // R7: never write into a buffer that still holds an unacknowledged packet
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !bank_full[wr_sel]);
    // R2: a closed packet never exceeds the maximum size
    assert_close_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> close_len <= LW'(MAX_PKT));
endmodule

// File: rtl/usb_in_pktbuf.sv
module usb_in_pktbuf #(
    parameter int MAX_PKT    = 64,
    parameter int TMO_CYCLES = 48000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] s_data,
    input  logic       s_last,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic       flush_now,
    input  logic       flush_tmo_en,
    output logic       ep_pkt_valid,
    output logic [6:0] ep_pkt_len,
    input  logic [5:0] ep_rd_addr,
    output logic [7:0] ep_rd_data,
    input  logic       ep_ack
);
    localparam int AW = $clog2(MAX_PKT);
    localparam int LW = $clog2(MAX_PKT + 1);

    logic          accept, wr_sel, fill_empty, close, tmo_hit, rd_sel;
    logic [AW-1:0] wr_addr;
    logic [LW-1:0] close_len;
    logic [1:0]    bank_full;
    logic [LW-1:0] bank_len [2];
    logic          release_pkt;

    inbuf_fill_fsm #(.MAX_PKT(MAX_PKT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_last(s_last),
        .flush_now(flush_now), .flush_tmo_en(flush_tmo_en), .tmo_hit(tmo_hit),
        .bank_full(bank_full), .s_ready(s_ready), .accept(accept),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .fill_empty(fill_empty),
        .close(close), .close_len(close_len)
    );

    inbuf_idle_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(accept || fill_empty), .expired(tmo_hit)
    );

    inbuf_store #(.MAX_PKT(MAX_PKT)) u_mem (
        .clk(clk), .wr_en(accept), .wr_bank(wr_sel), .wr_addr(wr_addr),
        .wr_data(s_data), .rd_bank(rd_sel), .rd_addr(AW'(ep_rd_addr)),
        .rd_data(ep_rd_data)
    );

    assign ep_pkt_valid = bank_full[rd_sel];
    assign ep_pkt_len   = 7'(bank_len[rd_sel]);
    assign release_pkt  = ep_ack && ep_pkt_valid;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_full[g] <= 1'b0;
                bank_len[g]  <= '0;
            end else if (close && (wr_sel == 1'(g))) begin
                bank_full[g] <= 1'b1;
                bank_len[g]  <= close_len;
            end else if (release_pkt && (rd_sel == 1'(g))) begin
                bank_full[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           rd_sel <= 1'b0;
        else if (release_pkt) rd_sel <= ~rd_sel;
    end

    // R7: both buffers closed means the user side is stalled
    assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full == 2'b11) |-> !s_ready);
    // R8: an offered packet stays offered and unchanged until acknowledged
    assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_pkt_valid && !ep_ack) |=> (ep_pkt_valid && $stable(ep_pkt_len)));
    // R9: acknowledge with nothing offered leaves the read side alone
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_ack && !ep_pkt_valid) |=> $stable(rd_sel));
    // R3: offered length never exceeds the maximum
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ep_pkt_valid |-> ep_pkt_len <= 7'(MAX_PKT));
endmodule

// File: tb/sim_usb_in_pktbuf.sv
module sim_usb_in_pktbuf;
    localparam int TMO = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0, s_valid = 1'b0, flush_now = 1'b0, flush_tmo_en = 1'b0;
    logic       s_ready, ep_pkt_valid, ep_ack = 1'b0;
    logic [6:0] ep_pkt_len;
    logic [5:0] ep_rd_addr = '0;
    logic [7:0] ep_rd_data;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    usb_in_pktbuf #(.MAX_PKT(64), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_last(s_last),
        .s_valid(s_valid), .s_ready(s_ready), .flush_now(flush_now),
        .flush_tmo_en(flush_tmo_en), .ep_pkt_valid(ep_pkt_valid),
        .ep_pkt_len(ep_pkt_len), .ep_rd_addr(ep_rd_addr),
        .ep_rd_data(ep_rd_data), .ep_ack(ep_ack)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        @(negedge clk);
        s_data = d; s_last = l; s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        ep_rd_addr = 6'(a);
        @(negedge clk);
        v = ep_rd_data;
    endtask

    task automatic ack();
        @(negedge clk); ep_ack = 1'b1;
        @(negedge clk); ep_ack = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", s_ready, 1);
        chk("R1 no packet after reset", ep_pkt_valid, 0);
    endtask

    task automatic t_short_last();
        int v;
        for (int i = 0; i < 5; i++) push(8'(8'h30 + i), i == 4);
        chk("R2 packet offered", ep_pkt_valid, 1);
        chk("R2 length", ep_pkt_len, 5);
        for (int i = 0; i < 5; i++) begin
            rd(i, v);
            chk("R10 byte", v, 8'h30 + i);
        end
        ack();
        idle(2);
        chk("R8 freed after ack", ep_pkt_valid, 0);
    endtask

    task automatic t_full_plain();
        int v;
        for (int i = 0; i < 64; i++) push(8'(i * 3), 1'b0);
        chk("R3 full closes", ep_pkt_valid, 1);
        chk("R3 length 64", ep_pkt_len, 64);
        rd(63, v);
        chk("R10 last byte", v, (63 * 3) & 8'hFF);
        ack();
        idle(5);
        chk("R3 no zero-length after plain full", ep_pkt_valid, 0);
    endtask

    task automatic t_full_last();
        for (int i = 0; i < 64; i++) push(8'(i), i == 63);
        chk("R4 full packet first", ep_pkt_len, 64);
        ack();
        idle(3);
        chk("R4 zero-length offered", ep_pkt_valid, 1);
        chk("R4 zero-length length", ep_pkt_len, 0);
        ack();
        idle(3);
        chk("R4 only one zero-length", ep_pkt_valid, 0);
    endtask

    task automatic t_flush_now();
        flush_tmo_en = 1'b0;
        for (int i = 0; i < 3; i++) push(8'(8'hA0 + i), 1'b0);
        idle(3 * TMO);
        chk("R6 no close without timeout enable", ep_pkt_valid, 0);
        @(negedge clk); flush_now = 1'b1;
        @(negedge clk); flush_now = 1'b0;
        chk("R5 flush closes partial", ep_pkt_valid, 1);
        chk("R5 flush length", ep_pkt_len, 3);
        ack();
        @(negedge clk); flush_now = 1'b1;
        idle(3);
        flush_now = 1'b0;
        idle(2);
        chk("R5 flush on empty gives nothing", ep_pkt_valid, 0);
    endtask

    task automatic t_timeout();
        flush_tmo_en = 1'b1;
        for (int i = 0; i < 4; i++) push(8'(8'hC0 + i), 1'b0);
        idle(TMO / 2);
        chk("R6 not yet timed out", ep_pkt_valid, 0);
        idle(TMO);
        chk("R6 timed out", ep_pkt_valid, 1);
        chk("R6 timeout length", ep_pkt_len, 4);
        flush_tmo_en = 1'b0;
        ack();
        idle(2);
    endtask

    task automatic t_pingpong();
        int v;
        push(8'h10, 1'b0); push(8'h11, 1'b1);
        idle(2);
        chk("R7 ready with one packet held", s_ready, 1);
        push(8'h20, 1'b0); push(8'h21, 1'b0); push(8'h22, 1'b1);
        idle(2);
        chk("R7 stalled with both held", s_ready, 0);
        chk("R8 oldest first", ep_pkt_len, 2);
        rd(1, v); chk("R8 first read", v, 8'h11);
        rd(1, v); chk("R8 reread unchanged", v, 8'h11);
        ack();
        chk("R8 second packet next", ep_pkt_len, 3);
        rd(2, v); chk("R10 second packet byte", v, 8'h22);
        idle(2);
        chk("R7 ready again", s_ready, 1);
        ack();
        idle(2);
    endtask

    task automatic t_stray_ack();
        int v;
        ack();
        idle(2);
        chk("R9 stray ack no packet", ep_pkt_valid, 0);
        push(8'h5A, 1'b1);
        chk("R9 packet intact length", ep_pkt_len, 1);
        rd(0, v); chk("R9 packet intact data", v, 8'h5A);
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_last();
        t_full_plain();
        t_full_last();
        t_flush_now();
        t_timeout();
        t_pingpong();
        t_stray_ack();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule